// File: doc/BRIEF.md
# Programmable square-wave tone generator

This block turns a system clock into an audible square wave. The half-period of the wave is given at run time as a 24-bit count of clock cycles. A cycle counter runs freely from zero. When it has covered the programmed number of cycles it starts again from zero, and the output level inverts at that moment. One full period of the wave is therefore twice the programmed value. At 33 MHz, a value of 37500 gives a 440 Hz tone.

A programmed value of zero is a rest: the level holds and does not oscillate. An enable input gates the output to zero as soon as it drops, while the counter and level keep running underneath. The block has no reset. Every register powers up at zero through its declared initial value. A melody sequencer drives the half-period input, and the output goes on to a speaker driver.

Top module: `tone_gen_top`

## Requirements
- R1: At start-up, with no reset, the counter and the level register are zero, so the output is 0 before the first inversion.
- R2: With a nonzero half-period P loaded while the count is zero, the level inverts on exactly every P-th rising clock edge (edges P, 2P, 3P, ...) and holds between them.
- R3: With P = 1 the level inverts on every rising clock edge.
- R4: With P = 0 the level holds its current value on every edge, so the output does not toggle.
- R5: Output-enable low forces the output to 0 in the same cycle; no clock edge is needed.
- R6: While output-enable is low, the counter and the level keep advancing. On re-enable, the output shows the level that an uninterrupted run would have.
- R7: If P is lowered to a value at or below the current count, the next edge restarts the count at zero and inverts the level. Further inversions then follow every P edges.
- R8: The counter only ever steps up by one or returns to zero; it never wraps through its full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| outEnable | input | 1 | High passes the wave; low forces the output to 0 |
| halfPeriod | input | 24 | Half-period in clock cycles; 0 means rest |
| squareOut | output | 1 | Square-wave output |

## Verification
Properties check on every cycle that the level inverts exactly when the count reaches the programmed limit, and never between limits. They also check that a rest holds the level, that an over-limit count restarts on the next edge, and that the counter never skips or wraps. Only the bench scenarios can show the results at the ports. These are the exact inversion edges for a sweep of small periods and for the 440 Hz setting, the immediate effect of the enable, and the phase that continues through a disabled window. They also cover the timing of the restart when the period shrinks mid-count.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int DEFAULT_CNT_W = 24;

  typedef struct packed {
    logic clear;
    logic advance;
    logic flip;
  } toneStrobe_t;
endpackage

// File: rtl/tone_ctrl.sv
module tone_ctrl
  import tone_pkg::*;
#(
  parameter int CNT_W = DEFAULT_CNT_W
) (
  input  logic [CNT_W-1:0] halfPeriod,
  input  logic [CNT_W-1:0] cnt,
  output toneStrobe_t      strobe
);
  logic             isRest;
  logic [CNT_W-1:0] lastCount;
  logic             atLimit;

  assign isRest    = (halfPeriod == '0);
  assign lastCount = halfPeriod - 1'b1;
  // Reaching or passing the limit restarts the count, which also covers a period that shrinks mid-count.
  assign atLimit   = !isRest && (cnt >= lastCount);

  always_comb begin
    strobe.clear   = isRest || atLimit;
    strobe.advance = !(isRest || atLimit);
    strobe.flip    = atLimit;
  end
endmodule

// File: rtl/tone_dpath.sv
module tone_dpath
  import tone_pkg::*;
#(
  parameter int CNT_W = DEFAULT_CNT_W
) (
  input  logic             clk,
  input  toneStrobe_t      strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             level
);
  logic [CNT_W-1:0] cntQ   = '0;
  logic             levelQ = 1'b0;
  logic             armed  = 1'b0;

  always_ff @(posedge clk) begin
    armed <= 1'b1;
    if (strobe.clear)        cntQ <= '0;
    else if (strobe.advance) cntQ <= cntQ + 1'b1;
    if (strobe.flip)         levelQ <= ~levelQ;
  end

  assign cnt   = cntQ;
  assign level = levelQ;

  // R8: the counter only steps up by one or returns to zero
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!armed)
    (cntQ != '0) |-> (cntQ == CNT_W'($past(cntQ) + 1'b1)));
endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top
  import tone_pkg::*;
#(
  parameter int CNT_W = DEFAULT_CNT_W
) (
  input  logic             clk,
  input  logic             outEnable,
  input  logic [CNT_W-1:0] halfPeriod,
  output logic             squareOut
);
  toneStrobe_t      strobe;
  logic [CNT_W-1:0] cnt;
  logic             level;
  logic             armed = 1'b0;

  always_ff @(posedge clk) armed <= 1'b1;

  tone_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .halfPeriod (halfPeriod),
    .cnt        (cnt),
    .strobe     (strobe)
  );

  tone_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk    (clk),
    .strobe (strobe),
    .cnt    (cnt),
    .level  (level)
  );

  assign squareOut = outEnable & level;

  // R2: the level inverts on the edge where the count sits at the limit
  a_r2_flip_at_limit: assert property (@(posedge clk) disable iff (!armed)
    (halfPeriod != '0 && cnt == halfPeriod - 1'b1) |=> (level != $past(level)));

  // R2: the level holds while the count is below the limit
  a_r2_hold_below: assert property (@(posedge clk) disable iff (!armed)
    (halfPeriod != '0 && cnt < halfPeriod - 1'b1) |=> (level == $past(level)));

  // R4: a rest holds the level and parks the counter at zero
  a_r4_rest_hold: assert property (@(posedge clk) disable iff (!armed)
    (halfPeriod == '0) |=> (level == $past(level) && cnt == '0));

  // R7: a count past the limit restarts on the next edge
  a_r7_restart: assert property (@(posedge clk) disable iff (!armed)
    (halfPeriod != '0 && cnt >= halfPeriod) |=> (cnt == '0));
endmodule

// File: tb/tb_tone_gen_top.sv
`timescale 1ns/1ps
module tb_tone_gen_top;
  logic        clk = 1'b0;
  logic        outEnable = 1'b1;
  logic [23:0] halfPeriod = '0;
  logic        squareOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic base = 1'b0;

  always #5 clk = ~clk;

  tone_gen_top dut (
    .clk        (clk),
    .outEnable  (outEnable),
    .halfPeriod (halfPeriod),
    .squareOut  (squareOut)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: squareOut=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    #2;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: output low before the first edge and while resting from power-up
    #1;
    chk("R1", squareOut, 1'b0);
    for (int i = 0; i < 5; i++) begin
      stepEdge();
      chk("R1", squareOut, 1'b0);
    end

    // R2/R3: sweep small periods, each from a zero count
    for (int p = 1; p <= 8; p++) begin
      halfPeriod = 24'(p);
      for (int k = 1; k <= 3 * p; k++) begin
        stepEdge();
        chk(p == 1 ? "R3" : "R2", squareOut, base ^ 1'(((k / p) & 1)));
      end
      base = ~base;
      halfPeriod = '0;
      for (int i = 0; i < 3; i++) begin
        stepEdge();
        chk("R4", squareOut, base);
      end
    end

    // R5/R6: a disabled window in the middle of a run with period 4
    halfPeriod = 24'd4;
    for (int k = 1; k <= 16; k++) begin
      logic en;
      @(posedge clk);
      #2;
      en = !(k >= 5 && k <= 10);
      outEnable = en;
      #1;
      if (en) chk("R6", squareOut, base ^ 1'(((k / 4) & 1)));
      else    chk("R5", squareOut, 1'b0);
    end
    outEnable = 1'b1;
    halfPeriod = '0;
    stepEdge();
    chk("R4", squareOut, base);

    // R7: a period that drops below the current count
    halfPeriod = 24'd8;
    for (int k = 1; k <= 5; k++) begin
      stepEdge();
      chk("R2", squareOut, base);
    end
    halfPeriod = 24'd3;
    for (int j = 1; j <= 7; j++) begin
      stepEdge();
      chk("R7", squareOut, base ^ 1'((((j + 2) / 3) & 1)));
    end
    base = ~base;

    // R4: a long rest stays constant
    halfPeriod = '0;
    for (int i = 0; i < 40; i++) begin
      stepEdge();
      chk("R4", squareOut, base);
    end

    // R2: the 440 Hz setting at 33 MHz
    halfPeriod = 24'd37500;
    for (int k = 1; k <= 75000; k++) begin
      stepEdge();
      if (k == 37499) chk("R2", squareOut, base);
      if (k == 37500) chk("R2", squareOut, ~base);
      if (k == 74999) chk("R2", squareOut, ~base);
      if (k == 75000) chk("R2", squareOut, base);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule